// File: doc/BRIEF.md
# Two-Step 32-bit-State Random Number Unit

This unit is the execution datapath behind a per-core random-number instruction. Software hands it a 32-bit generator state together with a one-cycle start strobe. The unit advances that state through a fixed number of xoroshiro-style iterations, two by default, each acting on a pair of 16-bit halves. It returns the advanced state, so that software can write it back for the next call. It also returns a 32-bit random word built from the 16-bit output of every iteration.

The generator uses the shift-rotate-xor triplet 14/2/7. An all-zero state is the one value the iteration can never leave. A nonzero state never reaches zero, so the sequence visits every nonzero state once per period of 2^32-1. The output of each iteration is the sum of the two halves, with its weakest bit (bit 0) replaced by the parity of the whole sum. When the supplied state is zero, the unit does not iterate. It reports the bad seed on a flag instead, so that software can test the flag right after seeding.

Results appear one clock after the start strobe, qualified by a one-cycle done pulse. They are held until the next start.

Top module: `prng_pair_step`

## Requirements
- R1: The state is split with s0 = state[15:0] and s1 = state[31:16]. One iteration computes t = s0^s1, then new s0 = rotl16(s0,14) ^ t ^ (t<<2), and new s1 = rotl16(t,7).
- R2: One start performs two iterations. next_state_o is the state after the second iteration, packed as {s1,s0}.
- R3: Each iteration's 16-bit output is taken from the state before that iteration is applied. It is (s0+s1) mod 2^16, with bit 0 replaced by the XOR of all 16 bits of that sum.
- R4: The output of the first iteration goes to result_o[31:16] and the output of the second goes to result_o[15:0].
- R5: done_o is high in exactly the cycle after a cycle in which start_i is high, and low otherwise.
- R6: A start with seed_i equal to zero gives next_state_o = 0, result_o = 0 and zero_seed_o = 1.
- R7: A start with a nonzero seed gives zero_seed_o = 0 and a nonzero next_state_o, including over long chains where each new state is fed back as the next seed.
- R8: In cycles without a start, next_state_o, result_o and zero_seed_o keep their values.
- R9: While rst_n is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; seed_i is taken in this cycle |
| seed_i | input | 32 | Current generator state {s1,s0} |
| next_state_o | output | 32 | State after the iterations |
| result_o | output | 32 | Random word, first iteration's output in the high half |
| zero_seed_o | output | 1 | Set when the seed of the last start was zero |
| done_o | output | 1 | One-cycle pulse marking valid results |

## Verification
The bench builds the unit with its default parameters: 16-bit halves, the 14/2/7 triplet and two iterations per start. With these values the 32-bit ports are fully used and a hand-computed vector can be checked exactly. Keeping start high every cycle and feeding the returned state straight back as the next seed covers thousands of consecutive iterations in a few thousand clocks. That chain exercises the no-zero property and the back-to-back timing of done_o together with the fixed and zero seeds.

// File: rtl/prng_pkg.sv
package prng_pkg;
    localparam int unsigned PRNG_HALF_W = 16;
    localparam int unsigned PRNG_SHL_A  = 14;
    localparam int unsigned PRNG_SHF_B  = 2;
    localparam int unsigned PRNG_ROT_C  = 7;
    localparam int unsigned PRNG_STEPS  = 2;
endpackage

// File: rtl/prng_mix.sv
// One state update of the generator: xor, rotate and shift on two halves.
module prng_mix #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned SHL_A  = 14,
    parameter int unsigned SHF_B  = 2,
    parameter int unsigned ROT_C  = 7
) (
    input  logic [HALF_W-1:0] lo_i,
    input  logic [HALF_W-1:0] hi_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    logic [HALF_W-1:0] cross_w;
    logic [HALF_W-1:0] lo_rot_w;
    logic [HALF_W-1:0] cross_rot_w;

    always_comb begin
        cross_w     = lo_i ^ hi_i;
        lo_rot_w    = (lo_i << SHL_A) | (lo_i >> (HALF_W - SHL_A));
        cross_rot_w = (cross_w << ROT_C) | (cross_w >> (HALF_W - ROT_C));
        lo_o        = lo_rot_w ^ cross_w ^ (cross_w << SHF_B);
        hi_o        = cross_rot_w;
    end
endmodule

// File: rtl/prng_out_word.sv
// Output word of one iteration: sum of halves, low bit swapped for parity.
module prng_out_word #(
    parameter int unsigned HALF_W = 16
) (
    input  logic [HALF_W-1:0] lo_i,
    input  logic [HALF_W-1:0] hi_i,
    output logic [HALF_W-1:0] word_o
);
    logic [HALF_W-1:0] sum_w;

    always_comb begin
        sum_w  = lo_i + hi_i;
        word_o = {sum_w[HALF_W-1:1], ^sum_w};
    end
endmodule

// File: rtl/prng_chain.sv
// Unrolled chain of STEPS iterations; word k lands in the k-th slice from the top.
module prng_chain #(
    parameter int unsigned HALF_W = 16,
    parameter int unsigned SHL_A  = 14,
    parameter int unsigned SHF_B  = 2,
    parameter int unsigned ROT_C  = 7,
    parameter int unsigned STEPS  = 2,
    localparam int unsigned STATE_W = 2 * HALF_W,
    localparam int unsigned RES_W   = STEPS * HALF_W
) (
    input  logic [STATE_W-1:0] seed_i,
    output logic [STATE_W-1:0] state_o,
    output logic [RES_W-1:0]   result_o
);
    logic [HALF_W-1:0] lo_w [STEPS+1];
    logic [HALF_W-1:0] hi_w [STEPS+1];

    assign lo_w[0] = seed_i[HALF_W-1:0];
    assign hi_w[0] = seed_i[STATE_W-1:HALF_W];

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        prng_out_word #(.HALF_W(HALF_W)) u_word (
            .lo_i   (lo_w[k]),
            .hi_i   (hi_w[k]),
            .word_o (result_o[RES_W-1-k*HALF_W -: HALF_W])
        );
        prng_mix #(
            .HALF_W (HALF_W),
            .SHL_A  (SHL_A),
            .SHF_B  (SHF_B),
            .ROT_C  (ROT_C)
        ) u_mix (
            .lo_i (lo_w[k]),
            .hi_i (hi_w[k]),
            .lo_o (lo_w[k+1]),
            .hi_o (hi_w[k+1])
        );
    end

    assign state_o = {hi_w[STEPS], lo_w[STEPS]};
endmodule

// File: rtl/prng_pair_step.sv
module prng_pair_step
    import prng_pkg::*;
#(
    parameter int unsigned HALF_W = PRNG_HALF_W,
    parameter int unsigned SHL_A  = PRNG_SHL_A,
    parameter int unsigned SHF_B  = PRNG_SHF_B,
    parameter int unsigned ROT_C  = PRNG_ROT_C,
    parameter int unsigned STEPS  = PRNG_STEPS,
    localparam int unsigned STATE_W = 2 * HALF_W,
    localparam int unsigned RES_W   = STEPS * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] seed_i,
    output logic [STATE_W-1:0] next_state_o,
    output logic [RES_W-1:0]   result_o,
    output logic               zero_seed_o,
    output logic               done_o
);
    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic [RES_W-1:0]   result;
        logic               zflag;
        logic               done;
    } out_reg_t;

    out_reg_t           regs_d, regs_q;
    logic [STATE_W-1:0] chain_state_w;
    logic [RES_W-1:0]   chain_result_w;
    logic               seed_zero_w;

    prng_chain #(
        .HALF_W (HALF_W),
        .SHL_A  (SHL_A),
        .SHF_B  (SHF_B),
        .ROT_C  (ROT_C),
        .STEPS  (STEPS)
    ) u_chain (
        .seed_i   (seed_i),
        .state_o  (chain_state_w),
        .result_o (chain_result_w)
    );

    assign seed_zero_w = (seed_i == '0);

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = start_i;
        if (start_i) begin
            regs_d.zflag = seed_zero_w;
            if (seed_zero_w) begin
                regs_d.state  = '0;
                regs_d.result = '0;
            end else begin
                regs_d.state  = chain_state_w;
                regs_d.result = chain_result_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign next_state_o = regs_q.state;
    assign result_o     = regs_q.result;
    assign zero_seed_o  = regs_q.zflag;
    assign done_o       = regs_q.done;

    p_done_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    p_no_spurious_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    p_zero_seed_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seed_i == '0) |=> (zero_seed_o && result_o == '0 && next_state_o == '0));
    p_never_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seed_i != '0) |=> (!zero_seed_o && next_state_o != '0));
    p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(result_o) && $stable(next_state_o) && $stable(zero_seed_o)));
endmodule

// File: tb/prng_pair_step_test.sv
module prng_pair_step_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic [31:0] next_state_o;
    logic [31:0] result_o;
    logic        zero_seed_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [31:0] exp_state = '0;
    logic [31:0] exp_result = '0;
    logic        exp_zero = 1'b0;
    logic        exp_done = 1'b0;

    always #2 clk = ~clk;

    prng_pair_step uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .seed_i       (seed_i),
        .next_state_o (next_state_o),
        .result_o     (result_o),
        .zero_seed_o  (zero_seed_o),
        .done_o       (done_o)
    );

    function automatic logic [15:0] rotl(input logic [15:0] x, input int r);
        return 16'((x << r) | (x >> (16 - r)));
    endfunction

    function automatic logic [15:0] out_of(input logic [15:0] a, input logic [15:0] b);
        int sum;
        int ones;
        sum = (int'(a) + int'(b)) % 65536;
        ones = 0;
        for (int i = 0; i < 16; i++) ones += (sum >> i) & 1;
        return {16'(sum) & 16'hFFFE} | 16'(ones % 2);
    endfunction

    // Reference of one start: R1 R2 R3 R4
    task automatic model(input logic [31:0] s, output logic [31:0] ns, output logic [31:0] res);
        logic [15:0] a, b, t;
        a = s[15:0];
        b = s[31:16];
        res = '0;
        for (int k = 0; k < 2; k++) begin
            res = {res[15:0], out_of(a, b)};
            t = a ^ b;
            a = rotl(a, 14) ^ t ^ 16'(t << 2);
            b = rotl(t, 7);
        end
        ns = {b, a};
    endtask

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] ns, res;
        if (!rst_n) begin
            exp_state <= '0; exp_result <= '0; exp_zero <= 1'b0; exp_done <= 1'b0;
        end else begin
            exp_done <= start_i;
            if (start_i) begin
                if (seed_i == 0) begin
                    exp_state <= '0; exp_result <= '0; exp_zero <= 1'b1;
                end else begin
                    model(seed_i, ns, res);
                    exp_state <= ns; exp_result <= res; exp_zero <= 1'b0;
                end
            end
        end
    end

    // Every-clock comparison against the model (R1..R9 via model)
    always @(negedge clk) begin
        if (!finished) begin
            check(next_state_o == exp_state, "R1 R2 R6 R8 R9 next_state", 64'(next_state_o), 64'(exp_state));
            check(result_o == exp_result, "R3 R4 R6 R8 R9 result", 64'(result_o), 64'(exp_result));
            check(zero_seed_o == exp_zero && done_o == exp_done, "R5 R6 R7 flags",
                  64'({zero_seed_o, done_o}), 64'({exp_zero, exp_done}));
        end
    end

    task automatic issue(input logic [31:0] s);
        @(negedge clk);
        start_i = 1'b1;
        seed_i = s;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        check(next_state_o == 0 && result_o == 0 && !zero_seed_o && !done_o, "R9 reset state",
              64'({next_state_o, result_o}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Hand-computed vector: R1 R2 R3 R4
        issue(32'h0000_0001);
        check(result_o == 32'h0001_4084, "R3 R4 known result", 64'(result_o), 64'h0001_4084);
        check(next_state_o == 32'h42A0_1290, "R1 R2 known state", 64'(next_state_o), 64'h42A0_1290);
        check(done_o == 1'b1, "R5 done pulse", 64'(done_o), 64'd1);
        @(negedge clk);
        check(done_o == 1'b0, "R5 done single cycle", 64'(done_o), 64'd0);

        // Zero seed: R6
        issue(32'h0000_0000);
        check(zero_seed_o && result_o == 0 && next_state_o == 0, "R6 zero seed",
              64'({zero_seed_o, result_o}), 64'h1_0000_0000);

        // Hold between starts: R8
        issue(32'hDEAD_BEEF);
        held = result_o;
        repeat (5) @(negedge clk);
        check(result_o == held && !done_o, "R8 hold", 64'(result_o), 64'(held));

        // Several patterns, back to back
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            start_i = 1'b1;
            seed_i = (i % 7 == 3) ? 32'h0 : (i % 5 == 0 ? (32'h1 << i % 32) : $urandom);
            @(negedge clk);
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);

        // Long chain with feedback: R7
        issue(32'h8000_0000);
        for (int i = 0; i < 3000; i++) begin
            start_i = 1'b1;
            seed_i = next_state_o;
            @(negedge clk);
            check(next_state_o != 0 && !zero_seed_o, "R7 chain nonzero", 64'(next_state_o), 64'd1);
        end
        start_i = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule